// File: doc/BRIEF.md
# Direct-Mapped Cache Controller

This block is a small cache that sits between a processor request port and a slower memory port. It keeps eight lines, and each line holds one 32-bit word with a tag, a valid flag and a modified flag. The 6-bit word address is split into two fields. The three low bits pick the line, and the three high bits are compared against that line's stored tag. A request that finds its word present finishes in the cycle it is presented. Any other request stalls the processor, fetches the word over the memory handshake and replaces whatever the line held before.

A static mode input selects between two write policies. In write-back mode, writes stay in the cache and mark the line modified. A modified line is copied out to memory before it is replaced. In write-through mode, every processor write is also sent to memory, and the processor waits for that write to finish. A write that misses first brings the line in and then merges its data, so both policies allocate on write.

Both ports use a level handshake. The processor holds `cpu_req` and its fields steady until it sees `cpu_ready` high at a rising edge. The cache holds `mem_req` and its fields steady until it sees `mem_ack` high at a rising edge, and the memory may take any number of cycles.

Top module: `dmc_cache`

## Requirements
- R1: The line index is `cpu_addr[2:0]` and the tag is `cpu_addr[5:3]`. A modified victim is written back at address {stored tag, index}.
- R2: After reset every line is invalid, so the first access to any address is a miss.
- R3: A request whose line is valid and whose stored tag equals the address tag is a hit. A read hit or a write-back write hit raises `cpu_ready` in the same cycle the request is presented, and a read hit returns the stored word on `cpu_rdata`.
- R4: A line whose valid flag is clear always misses, even when its stored tag equals the address tag.
- R5: On a miss `cpu_ready` stays low while a memory read of `cpu_addr` is outstanding. The returned word replaces the line, and a read then returns that word.
- R6: In write-back mode (`wb_mode`=1) a write hit updates the line, marks it modified and causes no memory traffic.
- R7: A miss on a modified line first writes the old word to memory and only then reads the new one, so memory always ends up holding the latest value.
- R8: A miss on a clean line issues no memory write.
- R9: In write-through mode (`wb_mode`=0) each processor write causes exactly one memory write of its address and data. `cpu_ready` rises only after that write is acknowledged.
- R10: A write miss allocates the line, so a later read of the same address hits and returns the written data.
- R11: Once raised, `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ack` is seen.
- R12: `cpu_ready` is high only while `cpu_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_mode | input | 1 | 1 selects write-back, 0 selects write-through |
| cpu_req | input | 1 | Processor request, held until accepted |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 6 | Word address |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Request completes at this rising edge |
| cpu_rdata | output | 32 | Read data, valid while `cpu_ready` is high |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 6 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completes the current request |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
The hardest case to reach is a miss on a modified line. It needs a write-back write to a line, followed by an access to a different tag at the same index, with the memory taking a random number of cycles for both the write-back and the refill. The stimulus draws its addresses from a small pool that shares index bits, so these conflicts happen often. It also alternates the write policy between blocks, which leaves some lines modified when write-through traffic begins. Directed cases come first: a tag that matches a freshly reset line, an eviction followed by a re-read of the evicted word, and allocation on write. At the end, memory is compared with the expected contents for every address that is not held modified in the cache.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVICT,
        ST_FILL,
        ST_WTHRU,
        ST_RESP
    } dmc_state_e;

    typedef struct packed {
        dmc_state_e st;
    } dmc_ctrl_t;

endpackage

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_dirty,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);

    localparam int LINES = 1 << IDX_W;

    typedef struct packed {
        logic              valid;
        logic              dirty;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } line_t;

    logic [LINES-1:0]  vld_vec;
    logic [LINES-1:0]  dty_vec;
    logic [TAG_W-1:0]  tag_arr [LINES];
    logic [DATA_W-1:0] dat_arr [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
        line_t line_d, line_q;

        always_comb begin
            line_d = line_q;
            if (wr_en && wr_idx == MY_IDX) begin
                line_d.valid = 1'b1;
                line_d.dirty = wr_dirty;
                line_d.tag   = wr_tag;
                line_d.data  = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) line_q <= '0;
            else        line_q <= line_d;
        end

        assign vld_vec[i] = line_q.valid;
        assign dty_vec[i] = line_q.dirty;
        assign tag_arr[i] = line_q.tag;
        assign dat_arr[i] = line_q.data;
    end

    assign rd_valid = vld_vec[rd_idx];
    assign rd_dirty = dty_vec[rd_idx];
    assign rd_tag   = tag_arr[rd_idx];
    assign rd_data  = dat_arr[rd_idx];

endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int IDX_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wb_mode,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [DATA_W-1:0]       cpu_wdata,
    output logic                    cpu_ready,
    input  logic                    rd_valid,
    input  logic                    rd_dirty,
    input  logic [ADDR_W-IDX_W-1:0] rd_tag,
    input  logic [DATA_W-1:0]       rd_data,
    output logic                    wr_en,
    output logic                    wr_dirty,
    output logic [DATA_W-1:0]       wr_data,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    input  logic                    mem_ack,
    input  logic [DATA_W-1:0]       mem_rdata
);

    localparam int TAG_W = ADDR_W - IDX_W;

    dmc_ctrl_t ctl_d, ctl_q;

    logic [IDX_W-1:0] a_idx;
    logic [TAG_W-1:0] a_tag;
    logic             hit;

    assign a_idx = cpu_addr[IDX_W-1:0];
    assign a_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign hit   = rd_valid && (rd_tag == a_tag);

    always_comb begin
        ctl_d     = ctl_q;
        cpu_ready = 1'b0;
        wr_en     = 1'b0;
        wr_dirty  = 1'b0;
        wr_data   = cpu_wdata;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cpu_addr;
        mem_wdata = cpu_wdata;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (hit) begin
                        if (cpu_we) begin
                            wr_en    = 1'b1;
                            wr_dirty = wb_mode | rd_dirty;
                            if (wb_mode) cpu_ready = 1'b1;
                            else         ctl_d.st  = ST_WTHRU;
                        end else begin
                            cpu_ready = 1'b1;
                        end
                    end else if (rd_valid && rd_dirty) begin
                        ctl_d.st = ST_EVICT;
                    end else begin
                        ctl_d.st = ST_FILL;
                    end
                end
            end
            ST_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {rd_tag, a_idx};
                mem_wdata = rd_data;
                if (mem_ack) ctl_d.st = ST_FILL;
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    wr_en    = 1'b1;
                    wr_data  = mem_rdata;
                    ctl_d.st = ST_IDLE;
                end
            end
            ST_WTHRU: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) ctl_d.st = ST_RESP;
            end
            ST_RESP: begin
                cpu_ready = 1'b1;
                ctl_d.st  = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE};
        else        ctl_q <= ctl_d;
    end

endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
    parameter int ADDR_W = 6,
    parameter int IDX_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_mode,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int TAG_W = ADDR_W - IDX_W;

    logic              rd_valid, rd_dirty;
    logic [TAG_W-1:0]  rd_tag;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en, wr_dirty;
    logic [DATA_W-1:0] wr_data;

    dmc_line_store #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (cpu_addr[IDX_W-1:0]),
        .rd_valid(rd_valid),
        .rd_dirty(rd_dirty),
        .rd_tag  (rd_tag),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_idx  (cpu_addr[IDX_W-1:0]),
        .wr_dirty(wr_dirty),
        .wr_tag  (cpu_addr[ADDR_W-1:IDX_W]),
        .wr_data (wr_data)
    );

    dmc_ctrl #(
        .ADDR_W(ADDR_W),
        .IDX_W (IDX_W),
        .DATA_W(DATA_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wb_mode  (wb_mode),
        .cpu_req  (cpu_req),
        .cpu_we   (cpu_we),
        .cpu_addr (cpu_addr),
        .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready),
        .rd_valid (rd_valid),
        .rd_dirty (rd_dirty),
        .rd_tag   (rd_tag),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_dirty (wr_dirty),
        .wr_data  (wr_data),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_ack  (mem_ack),
        .mem_rdata(mem_rdata)
    );

    assign cpu_rdata = rd_data;

endmodule

// File: rtl/dmc_cache_chk.sv
module dmc_cache_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wb_mode,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack
);

    assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

    assert_ready_with_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_req);

    assert_stall_during_mem_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready);

    assert_fill_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (mem_addr == cpu_addr));

    assert_wthru_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_we && !wb_mode) |-> $past(mem_ack));

endmodule

bind dmc_cache dmc_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wb_mode  (wb_mode),
    .cpu_req  (cpu_req),
    .cpu_we   (cpu_we),
    .cpu_addr (cpu_addr),
    .cpu_ready(cpu_ready),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack)
);

// File: tb/tb_dmc_cache.sv
module tb_dmc_cache;

    localparam time CYC = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wb_mode = 1'b1;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [5:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [5:0]  mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    dmc_cache dut (.*);

    always #(CYC/2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem    [64];
    logic [31:0] golden [64];
    logic        mvalid [8];
    logic        mdirty [8];
    logic [2:0]  mtag   [8];

    int          acc_wr, acc_rd;
    logic [5:0]  first_wr_addr;
    logic [5:0]  rd_addr_seen;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory model: random latency of 0..3 extra cycles, one-cycle ack
    initial begin
        int lat = -1;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (rst_n && mem_req) begin
                if (lat < 0) lat = int'($urandom % 4);
                if (lat == 0) begin
                    lat = -1;
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        if (acc_wr == 0) first_wr_addr = mem_addr;
                        acc_wr++;
                        chk(mem_wdata == golden[mem_addr], "R7", "memory write data",
                            mem_wdata, golden[mem_addr]);
                        mem[mem_addr] = mem_wdata;
                    end else begin
                        acc_rd++;
                        rd_addr_seen = mem_addr;
                        mem_rdata = mem[mem_addr];
                    end
                end else begin
                    lat--;
                end
            end
        end
    end

    task automatic access(input bit we, input logic [5:0] a, input logic [31:0] d);
        logic [2:0]  idx = a[2:0];
        logic [2:0]  tg  = a[5:3];
        bit          exp_hit  = mvalid[idx] && (mtag[idx] == tg);
        bit          exp_fast = exp_hit && !(we && !wb_mode);
        bit          exp_evict = !exp_hit && mvalid[idx] && mdirty[idx];
        int          exp_wr = (exp_evict ? 1 : 0) + ((we && !wb_mode) ? 1 : 0);
        int          exp_rd = exp_hit ? 0 : 1;
        logic [5:0]  victim = {mtag[idx], idx};
        logic [31:0] got = '0;
        bit          done = 0;
        int          cyc = 0;
        @(negedge clk);
        if (we) golden[a] = d;
        acc_wr = 0;
        acc_rd = 0;
        cpu_req = 1'b1;
        cpu_we = we;
        cpu_addr = a;
        cpu_wdata = d;
        while (!done) begin
            #(CYC/4);
            if (cyc == 0)
                chk(cpu_ready == exp_fast, exp_hit ? "R3" : "R5",
                    "ready in first cycle", cpu_ready, exp_fast);
            if (cpu_ready) begin
                done = 1;
                got = cpu_rdata;
            end else if (cyc > 60) begin
                done = 1;
                chk(0, "R5", "access never completed", cyc, 60);
            end
            cyc++;
            @(negedge clk);
        end
        cpu_req = 1'b0;
        if (!we)
            chk(got == golden[a], exp_hit ? "R3" : "R5", "read data", got, golden[a]);
        chk(acc_wr == exp_wr, we && !wb_mode ? "R9" : (exp_evict ? "R7" : "R8"),
            "memory write count", acc_wr, exp_wr);
        chk(acc_rd == exp_rd, "R5", "memory read count", acc_rd, exp_rd);
        if (exp_evict)
            chk(first_wr_addr == victim, "R1", "eviction address", first_wr_addr, victim);
        if (!exp_hit && acc_rd > 0)
            chk(rd_addr_seen == a, "R1", "refill address", rd_addr_seen, a);
        if (!exp_hit) begin
            mvalid[idx] = 1'b1;
            mtag[idx] = tg;
            mdirty[idx] = 1'b0;
        end
        if (we && wb_mode) mdirty[idx] = 1'b1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CYC * 150000);
        chk(0, "R5", "watchdog expired", 0, 1);
        finish_run();
    end

    logic [5:0] pool [12];

    initial begin
        void'($urandom(32'h5eed_c0de));
        for (int i = 0; i < 64; i++) begin
            mem[i] = $urandom;
            golden[i] = mem[i];
        end
        for (int i = 0; i < 8; i++) begin
            mvalid[i] = 1'b0;
            mdirty[i] = 1'b0;
            mtag[i] = '0;
        end
        for (int i = 0; i < 12; i++) pool[i] = 6'($urandom % 64);
        acc_wr = 0;
        acc_rd = 0;
        first_wr_addr = '0;
        rd_addr_seen = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #(CYC/4);
        chk(cpu_ready == 1'b0 && mem_req == 1'b0, "R12", "idle outputs after reset",
            {cpu_ready, mem_req}, 0);

        // R2/R4: tag 0 matches the reset tag value but the line is invalid
        access(0, 6'd0, 0);
        access(0, 6'd0, 0);                 // R3 hit
        access(1, 6'd0, 32'hDEAD_0001);     // R6 write hit, no traffic
        access(0, 6'd8, 0);                 // R7 evicts modified word at 0
        access(0, 6'd0, 0);                 // R7 evicted word comes back from memory
        access(0, 6'd16, 0);                // R8 clean victim
        access(1, 6'd35, 32'hA110_C035);    // R10 write miss allocates
        access(0, 6'd35, 0);                // R10 read hits allocated data
        chk(mdirty[3] == 1'b1, "R10", "model marks allocated line", mdirty[3], 1);
        @(negedge clk); wb_mode = 1'b0;
        access(1, 6'd5, 32'h7777_0005);     // R9 write-through miss
        access(1, 6'd5, 32'h7777_1005);     // R9 write-through hit
        access(1, 6'd43, 32'h0BAD_002B);    // R7 leftover modified line at index 3

        for (int blk = 0; blk < 8; blk++) begin
            @(negedge clk);
            wb_mode = blk[0] ? 1'b0 : 1'b1;
            for (int k = 0; k < 60; k++) begin
                logic [5:0] a = ($urandom % 4 == 0) ? 6'($urandom % 64) : pool[$urandom % 12];
                access(($urandom % 2) == 1, a, $urandom);
            end
        end

        // R7: memory is current for every word not held modified
        begin
            int bad = 0;
            for (int a = 0; a < 64; a++) begin
                logic [2:0] ix = 3'(a % 8);
                bit held = mvalid[ix] && mdirty[ix] && (mtag[ix] == 3'(a / 8));
                if (!held && mem[a] != golden[a]) bad++;
            end
            chk(bad == 0, "R7", "stale memory words", bad, 0);
        end
        finish_run();
    end

endmodule